// File: doc/BRIEF.md
# PWM Event Generator

This block produces one pulse-width-modulated output from a free-running counter. The counter either counts down from a period value to zero and reloads, or counts up from zero to the period value and back down. It is compared every cycle against the period value, zero, and two compare values (A and B). A hit on one of these values is an event, and compare hits are split by the direction the counter is moving.

Each event has a two-bit action code in an action word. The code decides what the event does to the output: leave it alone, toggle it, drive it low or drive it high. When several events coincide, one fixed priority picks the single action that is applied.

A small write port sets the period, both compare values, the counting mode and the action word. The period, the compare values and the mode are held as pending values. They move into use only when the counter sits at zero, so a running period is never cut short. The action word takes effect on the cycle after it is written.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset the output is 0, the count is 0, the direction flag is 0, the mode is count-down and every action code is 0, so events leave the output at 0.
- R2: Action codes: 0 leaves the output unchanged, 1 inverts it, 2 drives it to 0, 3 drives it to 1.
- R3: Action word fields: bits 1:0 zero reached, bits 3:2 period value reached, bits 5:4 compare A while counting up, bits 7:6 compare A while counting down, bits 9:8 compare B while counting up, bits 11:10 compare B while counting down.
- R4: In count-down mode (mode bit 0) the count falls by one each cycle. At zero it reloads the period value on the next cycle.
- R5: In up/down mode (mode bit 1) the count leaves zero at 1 and rises by one each cycle up to the period value. It then falls by one each cycle back to zero, and repeats. With a period value of 0 the count stays at 0.
- R6: Compare events for the counting-up direction never fire in count-down mode.
- R7: When events coincide, the first non-zero action in this order is applied: compare B, compare A, period value reached, zero reached.
- R8: Write addresses: 0 period value, 1 compare A, 2 compare B, 3 mode (data bit 0), 4 action word (data bits 11:0). Period, compare and mode writes take effect only on the cycle after the count is at zero. An action word write applies from the next cycle.
- R9: The output changes only on the clock edge that ends a cycle in which an event with a non-zero action is seen on the count. The new value is visible one cycle after the count shows the event value.
- R10: The direction output is 1 exactly when up/down mode is counting up. A cycle at zero that was reached by counting down still reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R8) |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 1 | PWM output |
| count | output | CNT_W | Current counter value |
| count_up | output | 1 | 1 while counting up |

## Verification
The bench builds the block with a 4-bit counter and a 12-bit write port. Every period value, every compare position and both modes can then be reached in a few dozen cycles. It sweeps both modes against period values 0, 1, 2, 7 and 15, four compare-A positions, a derived compare-B position and four action words that use every code in every field. This covers coincident events at zero and at the turning point, period values of zero, and writes landing in the middle of a period.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  localparam int ADDR_W = 3;
  localparam int NUM_EV = 6;
  localparam int ACTW_W = 2 * NUM_EV;

  localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPA   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPB   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACTION = 3'd4;

  // event index equals field position; a higher index wins
  localparam int EV_ZERO = 0;
  localparam int EV_PER  = 1;
  localparam int EV_AUP  = 2;
  localparam int EV_ADN  = 3;
  localparam int EV_BUP  = 4;
  localparam int EV_BDN  = 5;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_FLIP = 2'd1,
    ACT_LOW  = 2'd2,
    ACT_HIGH = 2'd3
  } act_e;

  function automatic act_e field_of(input logic [ACTW_W-1:0] w, input int idx);
    return act_e'(w[2*idx +: 2]);
  endfunction

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_FLIP: return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              at_zero,
  output logic [CNT_W-1:0]  per_pend,
  output logic              ud_pend,
  output logic [CNT_W-1:0]  per_act,
  output logic [CNT_W-1:0]  cmpa_act,
  output logic [CNT_W-1:0]  cmpb_act,
  output logic              ud_act,
  output logic [ACTW_W-1:0] act_word
);

  logic [CNT_W-1:0] cmpa_pend, cmpb_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_pend  <= '0;
      cmpa_pend <= '0;
      cmpb_pend <= '0;
      ud_pend   <= 1'b0;
      act_word  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_PERIOD: per_pend  <= wr_data[CNT_W-1:0];
        ADR_CMPA:   cmpa_pend <= wr_data[CNT_W-1:0];
        ADR_CMPB:   cmpb_pend <= wr_data[CNT_W-1:0];
        ADR_MODE:   ud_pend   <= wr_data[0];
        ADR_ACTION: act_word  <= wr_data[ACTW_W-1:0];
        default: ;
      endcase
    end
  end

  // pending values move into use only at the zero point of the count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
      ud_act   <= 1'b0;
    end else if (at_zero) begin
      per_act  <= per_pend;
      cmpa_act <= cmpa_pend;
      cmpb_act <= cmpb_pend;
      ud_act   <= ud_pend;
    end
  end

endmodule

// File: rtl/pwm_evt_counter.sv
module pwm_evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] per_pend,
  input  logic             ud_pend,
  input  logic [CNT_W-1:0] per_act,
  input  logic             ud_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             up_q,
  output logic             at_zero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             up_d;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q - ONE;
    up_d  = up_q;
    if (at_zero) begin
      if (ud_pend) begin
        cnt_d = (per_pend == '0) ? '0 : ONE;
        up_d  = 1'b1;
      end else begin
        cnt_d = per_pend;
        up_d  = 1'b0;
      end
    end else if (ud_act && up_q) begin
      if (cnt_q == per_act) begin
        up_d = 1'b0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud_act && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - ONE));

  // R5
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_act && up_q && cnt_q != '0 && cnt_q != per_act) |=> cnt_q == CNT_W'($past(cnt_q) + ONE));

  // R8
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(per_act));

endmodule

// File: rtl/pwm_evt_events.sv
module pwm_evt_events
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              up_q,
  input  logic              ud_act,
  input  logic [CNT_W-1:0]  per_act,
  input  logic [CNT_W-1:0]  cmpa_act,
  input  logic [CNT_W-1:0]  cmpb_act,
  input  logic [ACTW_W-1:0] act_word,
  output logic [NUM_EV-1:0] hit,
  output act_e              sel_act
);

  logic a_match, b_match;

  assign a_match = (cnt_q == cmpa_act);
  assign b_match = (cnt_q == cmpb_act);

  assign hit[EV_ZERO] = (cnt_q == '0);
  assign hit[EV_PER]  = (cnt_q == per_act);
  assign hit[EV_AUP]  = a_match &&  up_q;
  assign hit[EV_ADN]  = a_match && !up_q;
  assign hit[EV_BUP]  = b_match &&  up_q;
  assign hit[EV_BDN]  = b_match && !up_q;

  // ascending scan: a later (higher priority) non-idle action overrides
  always_comb begin
    sel_act = ACT_KEEP;
    for (int i = 0; i < NUM_EV; i++) begin
      if (hit[i] && field_of(act_word, i) != ACT_KEEP) sel_act = field_of(act_word, i);
    end
  end

  // R6
  no_up_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ud_act |-> !(hit[EV_AUP] || hit[EV_BUP]));

endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic [CNT_W-1:0]  count,
  output logic              count_up
);

  logic [CNT_W-1:0]  per_pend, per_act, cmpa_act, cmpb_act, cnt_q;
  logic              ud_pend, ud_act, up_q, at_zero;
  logic [ACTW_W-1:0] act_word;
  logic [NUM_EV-1:0] hit;
  act_e              sel_act;

  pwm_evt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .at_zero(at_zero), .per_pend(per_pend), .ud_pend(ud_pend), .per_act(per_act),
    .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .ud_act(ud_act), .act_word(act_word)
  );

  pwm_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .per_pend(per_pend), .ud_pend(ud_pend),
    .per_act(per_act), .ud_act(ud_act), .cnt_q(cnt_q), .up_q(up_q), .at_zero(at_zero)
  );

  pwm_evt_events #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .up_q(up_q), .ud_act(ud_act),
    .per_act(per_act), .cmpa_act(cmpa_act), .cmpb_act(cmpb_act),
    .act_word(act_word), .hit(hit), .sel_act(sel_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= apply_act(sel_act, pwm_out);
  end

  assign count    = cnt_q;
  assign count_up = up_q;

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act == ACT_KEEP) |=> $stable(pwm_out));

  // R2
  flip_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act == ACT_FLIP) |=> pwm_out != $past(pwm_out));

  // R2
  low_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act == ACT_LOW) |=> !pwm_out);

  // R2
  high_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act == ACT_HIGH) |=> pwm_out);

endmodule

// File: tb/sim_pwm_event_gen.sv
`timescale 1ns/1ps
module sim_pwm_event_gen;

  localparam int W  = 4;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          pwm_out, count_up;
  logic [W-1:0]  count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int m_cnt, m_up, m_out, m_per, m_ca, m_cb, m_ud, p_per, p_ca, p_cb, p_ud, m_act;

  always #10 clk = ~clk;

  pwm_event_gen #(.CNT_W(W), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .count(count), .count_up(count_up)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int fld(input int idx);
    return (m_act >> (2 * idx)) & 3;
  endfunction

  // one clock: drive inputs, advance the reference, compare at the falling edge
  task automatic tick(input bit we, input int adr, input int dat);
    int code, n_cnt, n_up;
    wr_en = we; wr_addr = 3'(adr); wr_data = DW'(dat);
    // R7 priority chain: B, then A, then period, then zero
    code = 0;
    if (m_cnt == m_cb && fld(m_up ? 4 : 5) != 0)      code = fld(m_up ? 4 : 5);
    else if (m_cnt == m_ca && fld(m_up ? 2 : 3) != 0) code = fld(m_up ? 2 : 3);
    else if (m_cnt == m_per && fld(1) != 0)           code = fld(1);
    else if (m_cnt == 0 && fld(0) != 0)               code = fld(0);
    case (code)
      1: m_out = 1 - m_out;
      2: m_out = 0;
      3: m_out = 1;
      default: ;
    endcase
    n_cnt = m_cnt - 1; n_up = m_up;
    if (m_cnt == 0) begin
      m_per = p_per; m_ca = p_ca; m_cb = p_cb; m_ud = p_ud;
      if (p_ud != 0) begin n_cnt = (p_per == 0) ? 0 : 1; n_up = 1; end
      else begin n_cnt = p_per; n_up = 0; end
    end else if (m_ud != 0 && m_up != 0) begin
      if (m_cnt == m_per) begin n_up = 0; n_cnt = m_cnt - 1; end
      else n_cnt = m_cnt + 1;
    end
    m_cnt = n_cnt; m_up = n_up;
    if (we) begin
      case (adr)
        0: p_per = dat % 16;
        1: p_ca  = dat % 16;
        2: p_cb  = dat % 16;
        3: p_ud  = dat & 1;
        4: m_act = dat & 12'hFFF;
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(m_ud != 0 ? "R5 count" : "R4 count", int'(count), m_cnt);
    chk("R10 direction", int'(count_up), m_up);
    chk("R2 R3 R7 R9 output", int'(pwm_out), m_out);
  endtask

  initial begin
    #(20 * 200000);
    chk("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_cnt = 0; m_up = 0; m_out = 0; m_per = 0; m_ca = 0; m_cb = 0; m_ud = 0;
    p_per = 0; p_ca = 0; p_cb = 0; p_ud = 0; m_act = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 output", int'(pwm_out), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 direction", int'(count_up), 0);
    // R1 default actions: output stays 0 while events fire
    tick(1, 0, 5);
    repeat (20) tick(0, 0, 0);
    chk("R1 idle output", int'(pwm_out), 0);

    // R6 count-down mode with only up-direction compare actions: output stays 0
    tick(1, 1, 3);
    tick(1, 2, 2);
    tick(1, 4, 12'h330);
    for (int k = 0; k < 30; k++) begin
      tick(0, 0, 0);
      chk("R6 no up events", int'(pwm_out), 0);
    end

    // R7 coincident B-up (set) and A-up (clear) at the turning point
    tick(1, 3, 1);
    tick(1, 0, 6);
    tick(1, 1, 6);
    tick(1, 2, 6);
    tick(1, 4, 12'h3E0);
    repeat (40) tick(0, 0, 0);

    // R8 sweep: writes land mid-period and are checked against reference
    for (int md = 0; md < 2; md++)
      for (int pi = 0; pi < 5; pi++)
        for (int ai = 0; ai < 4; ai++)
          for (int pat = 0; pat < 4; pat++) begin
            int per, ca, cb, aw;
            per = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 2 : (pi == 3) ? 7 : 15;
            ca = ai * 5;
            cb = (ca + per + pat) % 16;
            aw = 0;
            for (int f = 0; f < 6; f++) aw = aw | (((f + pat + ai) % 4) << (2 * f));
            tick(1, 3, md);
            tick(1, 0, per);
            tick(1, 1, ca);
            tick(1, 2, cb);
            tick(1, 4, aw);
            repeat (2 * per + 8) tick(0, 0, 0);
          end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule